// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Wakeup

This block collects a set of level-sensitive interrupt request lines from peripherals and presents two summary signals to the processor core. The first is an interrupt request, raised when any pending source is unmasked. The second is a wakeup request, raised only while the core reports that it is idle, when any pending source has its wakeup enable set. The two enables are independent. A source that is masked but wakeup-enabled can therefore rouse a sleeping core without producing an interrupt.

Each request line passes through a two-stage synchronizer. The synchronized value forms a pending-status register that software can read but cannot write. A pending bit clears by itself once the peripheral drops its line. A small word-wide register port gives access to the status, mask and wakeup-enable registers. All three share one bit-per-source layout: bit i belongs to request line i.

Top module: `pic_wake_ctrl`

## Requirements
- R1: Pending status bit i equals the value that `irq_req[i]` had two rising clock edges earlier. This holds both when a bit sets and when it clears.
- R2: A write to address 0 (status) or to address 3 (unused) changes no register. The status still follows the request lines, and the mask and wakeup-enable values are unchanged.
- R3: After a synchronous active-low reset, status reads all zeros, the mask reads all zeros, and the wakeup enable reads all ones in its NUM_SRC valid bits.
- R4: `irq_out` is high exactly when at least one bit of (status AND mask) is set, whatever the level of `core_idle`.
- R5: `wake_out` is high exactly when `core_idle` is high and at least one bit of (status AND wakeup-enable) is set. It is low whenever `core_idle` is low.
- R6: A pending source that is wakeup-enabled but masked drives `wake_out` high while idle and leaves `irq_out` low.
- R7: The wakeup-enable register takes the written value on the edge after the write, whether the core is idle or running.
- R8: Register bits at position NUM_SRC and above read as zero and ignore written ones.
- R9: Reads are combinational on `reg_addr`. Address 0 returns status, 1 returns the mask, 2 returns wakeup-enable and 3 returns zero. Writes to 1 and 2 take effect on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NUM_SRC | Level-sensitive peripheral request lines |
| core_idle | input | 1 | High while the core is idled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 status, 1 mask, 2 wake enable, 3 none) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| irq_out | output | 1 | Combined unmasked interrupt request |
| wake_out | output | 1 | Wakeup request to an idle core |

## Verification
The latency assertion assumes that `irq_req` is a clean level sampled on rising edges. It also assumes that no reset arrives while the two-edge window is being measured. The bench therefore changes every input a short delay after the falling edge and holds it across the next rising edge. The write-effect assertions assume that `reg_addr` and `reg_wdata` are stable at the edge that carries `reg_wr`. The bench drives the strobe and its data together in one step. `core_idle` is toggled freely, because the requirements place no condition on it.

// File: rtl/pic_pkg.sv
// Package: shared register address codes for the peripheral interrupt controller.
// Assumes a two-bit register address.
package pic_pkg;
    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_WAKE = 2'd2,
        ADDR_NONE = 2'd3
    } pic_addr_e;
endpackage

// File: rtl/pic_sync.sv
// Module: two-flop synchronizer per request line. The second stage is the
// pending-status register. Assumes request lines are level-sensitive.
module pic_sync #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    output logic [NUM_SRC-1:0] status
);
    logic [NUM_SRC-1:0] stage1;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_bit
        // Purpose: move one request bit through two flops into status.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[gi] <= 1'b0;
                status[gi] <= 1'b0;
            end else begin
                stage1[gi] <= req_in[gi];
                status[gi] <= stage1[gi];
            end
        end
    end

    // Checker state: counts edges since reset, saturating at two.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    a_r1_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (status == $past(req_in, 2)));
endmodule

// File: rtl/pic_regs.sv
// Module: mask and wakeup-enable registers with a combinational read mux.
// Status is read-only. Bits at NUM_SRC and above read zero.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] wake_en,
    output logic [REG_W-1:0]   rdata
);
    localparam int PAD_W = REG_W - NUM_SRC;

    pic_addr_e sel;
    assign sel = pic_addr_e'(addr);

    // Purpose: load the mask on a write to its address; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask <= '0;
        else if (wr_en && sel == ADDR_MASK) mask <= wdata[NUM_SRC-1:0];
    end

    // Purpose: load wake enable on a write to its address; set it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         wake_en <= '1;
        else if (wr_en && sel == ADDR_WAKE) wake_en <= wdata[NUM_SRC-1:0];
    end

    // Purpose: return the selected register, zero-extended.
    always_comb begin
        rdata = '0;
        case (sel)
            ADDR_STAT: rdata[NUM_SRC-1:0] = status;
            ADDR_MASK: rdata[NUM_SRC-1:0] = mask;
            ADDR_WAKE: rdata[NUM_SRC-1:0] = wake_en;
            default:   rdata = '0;
        endcase
    end

    if (PAD_W > 0) begin : g_pad
        logic unused_hi;
        assign unused_hi = ^wdata[REG_W-1:NUM_SRC];
        a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[REG_W-1:NUM_SRC] == '0);
    end

    a_r2_status_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == ADDR_STAT || sel == ADDR_NONE)) |=>
            (mask == $past(mask) && wake_en == $past(wake_en)));

    a_r7_wake_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_WAKE) |=> (wake_en == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/pic_combine.sv
// Module: reduces status against mask and wake enable into the two core
// requests. The wake request is gated by core idle. Purely combinational.
// The clock is used only by the checks.
module pic_combine #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] wake_en,
    input  logic               core_idle,
    output logic               irq_out,
    output logic               wake_out
);
    // Purpose: form interrupt and wakeup requests from pending sources.
    always_comb begin
        irq_out  = |(status & mask);
        wake_out = core_idle & (|(status & wake_en));
    end

    a_r5_running_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !core_idle |-> !wake_out);

    a_r6_masked_source_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (core_idle && ((status & wake_en & ~mask) != '0)) |-> wake_out);

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == '0) |-> !irq_out);
endmodule

// File: rtl/pic_wake_ctrl.sv
// Module: top of the peripheral interrupt controller. Synchronizes the request
// lines into status and holds the mask and wake-enable registers. Drives the
// combined interrupt and the idle-gated wakeup request.
module pic_wake_ctrl #(
    parameter int NUM_SRC = 8,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               core_idle,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq_out,
    output logic               wake_out
);
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] wake_en;

    pic_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_in(irq_req), .status(status)
    );

    pic_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .status(status), .mask(mask),
        .wake_en(wake_en), .rdata(reg_rdata)
    );

    pic_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk(clk), .rst_n(rst_n), .status(status), .mask(mask),
        .wake_en(wake_en), .core_idle(core_idle),
        .irq_out(irq_out), .wake_out(wake_out)
    );
endmodule

// File: tb/pic_wake_ctrl_tb.sv
module pic_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int RW = 32;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          core_idle = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          irq_out, wake_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit armed  = 0;
    string phase = "R3";

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_wake_ctrl #(.NUM_SRC(N), .REG_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_idle(core_idle),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .wake_out(wake_out)
    );

    // Reference model: a delay queue for the request lines plus two plain registers.
    logic [N-1:0] q_req[$];
    logic [N-1:0] m_stat, m_mask, m_wake;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_req = {};
            q_req.push_back('0);
            m_stat = '0; m_mask = '0; m_wake = '1;
        end else begin
            q_req.push_back(irq_req);
            m_stat = q_req.pop_front();
            if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[N-1:0];
            if (reg_wr && reg_addr == 2'd2) m_wake = reg_wdata[N-1:0];
        end
        armed = 1;
    end

    task automatic chk(input bit ok, input string what, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge. The tag in phase names the requirement under test.
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [RW-1:0] e_rd;
            logic e_irq, e_wake;
            e_rd = '0;
            case (reg_addr)
                2'd0: e_rd[N-1:0] = m_stat;
                2'd1: e_rd[N-1:0] = m_mask;
                2'd2: e_rd[N-1:0] = m_wake;
                default: e_rd = '0;
            endcase
            e_irq  = |(m_stat & m_mask);
            e_wake = core_idle & (|(m_stat & m_wake));
            chk(reg_rdata == e_rd, "rdata (R9)", reg_rdata, e_rd);
            chk(irq_out == e_irq, "irq_out (R4)", {31'd0, irq_out}, {31'd0, e_irq});
            chk(wake_out == e_wake, "wake_out (R5)", {31'd0, wake_out}, {31'd0, e_wake});
        end
    end

    task automatic step(input logic [N-1:0] req, input bit idle, input bit wr,
                        input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        #1;
        irq_req = req; core_idle = idle; reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        step('0, 0, 0, 2'd0, '0);
        rst_n = 1'b1;
        // R3: reset values of status, mask and wake enable.
        phase = "R3";
        step('0, 0, 0, 2'd1, '0);
        step('0, 0, 0, 2'd2, '0);
        step('0, 0, 0, 2'd0, '0);
        // R1: set and clear latency, observed through the status read.
        phase = "R1";
        step(8'h05, 0, 0, 2'd0, '0);
        repeat (3) step(8'h05, 0, 0, 2'd0, '0);
        step(8'h00, 0, 0, 2'd0, '0);
        repeat (3) step(8'h00, 0, 0, 2'd0, '0);
        // R4: mask some sources, and show irq_out does not depend on idle.
        phase = "R4";
        step('0, 0, 1, 2'd1, 32'h0000_000F);
        step(8'h20, 0, 0, 2'd1, '0);
        repeat (3) step(8'h20, 1, 0, 2'd0, '0);
        repeat (3) step(8'h22, 1, 0, 2'd0, '0);
        repeat (3) step(8'h22, 0, 0, 2'd0, '0);
        // R6: masked but wake-enabled source wakes the idle core with no interrupt.
        phase = "R6";
        step('0, 0, 1, 2'd1, 32'h0000_0000);
        step('0, 0, 1, 2'd2, 32'h0000_00F0);
        repeat (3) step(8'h10, 1, 0, 2'd0, '0);
        // R5: the same pending source does not wake a running core.
        phase = "R5";
        repeat (3) step(8'h10, 0, 0, 2'd2, '0);
        // R7: write wake enable while idle, then while running.
        phase = "R7";
        step(8'h10, 1, 1, 2'd2, 32'h0000_0001);
        step(8'h10, 1, 0, 2'd2, '0);
        step(8'h01, 0, 1, 2'd2, 32'h0000_0003);
        repeat (3) step(8'h01, 1, 0, 2'd2, '0);
        // R2: writes to the status address and the unused address change nothing.
        phase = "R2";
        step(8'h01, 1, 1, 2'd0, 32'hFFFF_FFFF);
        step(8'h01, 1, 1, 2'd3, 32'hFFFF_FFFF);
        step(8'h01, 1, 0, 2'd1, '0);
        step(8'h01, 1, 0, 2'd2, '0);
        step(8'h01, 1, 0, 2'd0, '0);
        step(8'h01, 1, 0, 2'd3, '0);
        // R8: upper bits read as zero after an all-ones write.
        phase = "R8";
        step(8'h01, 1, 1, 2'd1, 32'hFFFF_FFFF);
        step(8'h01, 1, 0, 2'd1, '0);
        step(8'h01, 1, 1, 2'd2, 32'hFFFF_FF00);
        step(8'h01, 1, 0, 2'd2, '0);
        // R9: mixed traffic over all addresses with pseudo-random inputs.
        phase = "R9";
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[7:0], lfsr[8], (lfsr[11:9] == 3'd0), lfsr[13:12], {lfsr[3:0], lfsr[31:4]});
        end
        // R3: reset again in the middle of activity.
        phase = "R3";
        step(8'hFF, 1, 0, 2'd2, '0);
        rst_n = 1'b0;
        step(8'hFF, 1, 0, 2'd2, '0);
        step(8'h00, 0, 0, 2'd2, '0);
        rst_n = 1'b1;
        step(8'h00, 0, 0, 2'd1, '0);
        step(8'h00, 0, 0, 2'd0, '0);
        step(8'h00, 0, 0, 2'd0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog %s actual=running expected=finished", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule